// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

This block is a sequential integer and fixed-point divider that retires one quotient bit per iteration step. A single datapath serves five operation kinds: unsigned and signed division of a 16-bit dividend by a 16-bit divisor, unsigned and signed division of a 32-bit dividend by a 16-bit divisor, and signed fractional division of two Q1.15 values giving a Q1.15 quotient. Every operation returns a 16-bit quotient and a 16-bit remainder together with an overflow flag.

An operation begins with a one-cycle `start` pulse carrying the mode code and the operands, which the block captures in that cycle. It then runs a fixed schedule of 18 iteration steps: 16 quotient-bit steps, one sign-correction step and one result-write step. Including the start cycle, a divide occupies 19 clock cycles. A `hold` input freezes the iteration at any step without losing the partial state, so an operation can be suspended and resumed. The results are registered and stay unchanged until the next completion.

Top module: `iter_divider`

## Requirements
- R1: Mode codes are 0 = unsigned 16/16, 1 = signed 16/16, 2 = unsigned 32/16, 3 = signed 32/16, 4 = signed fractional 16/16. A `start` with `busy` low and a mode code of 0 to 4 is accepted; a `start` with a mode code of 5, 6 or 7 is ignored and `busy` stays low.
- R2: In the 32/16 modes the dividend is `dividend[31:16]` as the upper word and `dividend[15:0]` as the lower word; the 16/16 and fractional modes use `dividend[15:0]` only and ignore `dividend[31:16]`. Operands are captured in the accepting cycle and later changes to the operand inputs have no effect on the running operation.
- R3: Unsigned modes return quotient = floor(N / D) and remainder = N mod D.
- R4: Signed modes (1 and 3) treat the operands as two's complement, return the quotient truncated toward zero and a remainder that carries the sign of the dividend, so that N = Q * D + R.
- R5: Fractional mode returns the signed quotient of (dividend[15:0] * 2^15) / divisor truncated toward zero, with the remainder of that division carrying the sign of the dividend.
- R6: `overflow` is set at completion when the divisor is zero or the true quotient lies outside 0..65535 (unsigned modes) or -32768..32767 (signed and fractional modes); quotient and remainder are then undefined. Otherwise `overflow` is clear.
- R7: With `hold` low, `busy` is high for the 18 cycles following the accepting edge and `done` is high for exactly one cycle, the 19th cycle counted from the start cycle; `busy` and `done` are never high together. A new `start` may be accepted in the `done` cycle.
- R8: Each cycle in which `hold` is high while `busy` is high delays completion by exactly one cycle and leaves the results unchanged.
- R9: A `start` received while `busy` is high is ignored: the running operation completes on its original schedule with its original operands.
- R10: After reset `busy`, `done`, `overflow`, `quotient` and `remainder` are all zero; `quotient`, `remainder` and `overflow` change only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (one-cycle pulse) |
| mode | input | 3 | Operation kind, codes in R1 |
| dividend | input | 32 | Dividend; lower word only in 16-bit and fractional modes |
| divisor | input | 16 | Divisor |
| hold | input | 1 | Freeze iteration while high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient of the last completed operation |
| remainder | output | 16 | Remainder of the last completed operation |
| overflow | output | 1 | Divide by zero or quotient out of range |

## Verification
The bound checker watches the handshake on every cycle: the single-cycle `done`, the exclusion of `busy` and `done`, the exact count of non-held busy cycles before completion, the freeze under `hold`, the rejection of a `start` while busy or with an unused mode code, the flag on a zero divisor and the stability of the results between completions. The arithmetic itself, the signs of quotient and remainder in each mode, the fractional scaling, the range limits of the overflow flag and the isolation from operand changes after capture are shown only by the bench scenarios, which compare every cycle against a behavioural model computing each result with wide integer division.

// File: rtl/divider_pkg.sv
// Package: shared types for the iterative divider.
// Holds the mode encoding, the per-operation sign/overflow flag bundle
// and a helper that tells accepted mode codes from unused ones.
package divider_pkg;

    typedef enum logic [2:0] {
        DM_U16  = 3'd0,
        DM_S16  = 3'd1,
        DM_U32  = 3'd2,
        DM_S32  = 3'd3,
        DM_FRAC = 3'd4
    } div_mode_e;

    typedef struct packed {
        logic q_neg;      // quotient must be negated at the end
        logic r_neg;      // remainder must be negated at the end
        logic signed_op;  // signed range applies to the quotient
        logic pre_ovf;    // divide by zero or upper word too large
    } div_flags_t;

    // True for the five mode codes the divider accepts.
    function automatic logic mode_is_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Combinational operand conditioning. Forms the unsigned magnitudes of
// the double-width dividend and the divisor for the selected mode, the
// sign-correction flags, and an early overflow flag (zero divisor, or an
// upper dividend word not below the divisor, which means the magnitude
// quotient needs more than W bits).
// Assumes: mode is one of the five valid codes when its outputs are used.
module div_operand_prep
    import divider_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]     mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output div_flags_t     flags
);

    localparam int NW = 2 * W;

    logic [W-1:0]  lo_word;
    logic [W-1:0]  lo_mag;
    logic [NW-1:0] full_mag;
    logic [W-1:0]  div_abs;
    logic          num_sign;
    logic          den_sign;
    logic          is_signed;

    assign lo_word  = dividend[W-1:0];
    assign lo_mag   = lo_word[W-1] ? -lo_word : lo_word;
    assign full_mag = dividend[NW-1] ? -dividend : dividend;
    assign div_abs  = divisor[W-1] ? -divisor : divisor;

    // Select the dividend magnitude and operand signs by mode.
    always_comb begin
        num_mag   = '0;
        num_sign  = 1'b0;
        den_sign  = 1'b0;
        is_signed = 1'b0;
        case (div_mode_e'(mode))
            DM_U16: begin
                num_mag = {{W{1'b0}}, lo_word};
            end
            DM_S16: begin
                num_mag   = {{W{1'b0}}, lo_mag};
                num_sign  = lo_word[W-1];
                den_sign  = divisor[W-1];
                is_signed = 1'b1;
            end
            DM_U32: begin
                num_mag = dividend;
            end
            DM_S32: begin
                num_mag   = full_mag;
                num_sign  = dividend[NW-1];
                den_sign  = divisor[W-1];
                is_signed = 1'b1;
            end
            DM_FRAC: begin
                num_mag   = {1'b0, lo_mag, {(W-1){1'b0}}};
                num_sign  = lo_word[W-1];
                den_sign  = divisor[W-1];
                is_signed = 1'b1;
            end
            default: begin
                num_mag = '0;
            end
        endcase
    end

    // Divisor magnitude and the flag bundle.
    always_comb begin
        den_mag         = is_signed ? div_abs : divisor;
        flags.q_neg     = num_sign ^ den_sign;
        flags.r_neg     = num_sign;
        flags.signed_op = is_signed;
        flags.pre_ovf   = (den_mag == '0) || (num_mag[NW-1:W] >= den_mag);
    end

endmodule

// File: rtl/div_iter_core.sv
// Module: div_iter_core
// Restoring shift-subtract engine. On load it takes a 2W-bit dividend
// magnitude and a W-bit divisor magnitude; each step shifts one dividend
// bit into the partial remainder and retires one quotient bit. After W
// steps part_rem holds the remainder and part_quo the quotient.
// Assumes: the upper dividend word is below the divisor; otherwise the
// results are meaningless (the caller flags that case as overflow).
module div_iter_core #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] num_in,
    input  logic [W-1:0]   den_in,
    output logic [W-1:0]   part_rem,
    output logic [W-1:0]   part_quo
);

    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] den_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    // Load the operands or advance one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (load) begin
            rem_q <= num_in[2*W-1:W];
            quo_q <= num_in[W-1:0];
            den_q <= den_in;
        end else if (step) begin
            rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign part_rem = rem_q;
    assign part_quo = quo_q;

endmodule

// File: rtl/div_sign_fix.sv
// Module: div_sign_fix
// Combinational final correction. Applies the quotient and remainder
// signs to the magnitudes from the engine and decides overflow from the
// early flag and the signed range of the quotient.
// Assumes: magnitudes are the engine's values after its W steps.
module div_sign_fix
    import divider_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  div_flags_t   flags,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         ovf_out
);

    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic range_bad;

    // Signed range: up to HALF when negative, below HALF when positive.
    always_comb begin
        if (flags.signed_op)
            range_bad = flags.q_neg ? (quo_mag > HALF) : quo_mag[W-1];
        else
            range_bad = 1'b0;
        ovf_out = flags.pre_ovf || range_bad;
        quo_out = flags.q_neg ? -quo_mag : quo_mag;
        rem_out = flags.r_neg ? -rem_mag : rem_mag;
    end

endmodule

// File: rtl/iter_divider.sv
// Module: iter_divider (top)
// Multi-mode iterative divider. Captures operands on an accepted start,
// runs DATA_W quotient-bit steps, one sign-correction step and one
// result-write step (DATA_W+2 steps), then pulses done for one cycle.
// Hold freezes the step counter and all partial state. Results stay
// registered until the next completion.
// Assumes: start is sampled only while idle; an unused mode is ignored.
module iter_divider
    import divider_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            mode,
    input  logic [2*DATA_W-1:0]   dividend,
    input  logic [DATA_W-1:0]     divisor,
    input  logic                  hold,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     quotient,
    output logic [DATA_W-1:0]     remainder,
    output logic                  overflow
);

    localparam int NUM_W = 2 * DATA_W;
    localparam int ITER  = DATA_W + 2;
    localparam int CNT_W = $clog2(ITER + 1);
    localparam logic [CNT_W-1:0] FIX_STEP  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ITER - 1);

    logic [NUM_W-1:0]  prep_num;
    logic [DATA_W-1:0] prep_den;
    div_flags_t        prep_flags;
    div_flags_t        flags_q;
    logic [CNT_W-1:0]  step_cnt;
    logic              accept;
    logic              advance;
    logic              bit_step;
    logic [DATA_W-1:0] core_rem;
    logic [DATA_W-1:0] core_quo;
    logic [DATA_W-1:0] fix_quo;
    logic [DATA_W-1:0] fix_rem;
    logic              fix_ovf;
    logic [DATA_W-1:0] stage_quo;
    logic [DATA_W-1:0] stage_rem;
    logic              stage_ovf;

    assign accept   = start && !busy && mode_is_valid(mode);
    assign advance  = busy && !hold;
    assign bit_step = advance && (step_cnt < FIX_STEP);

    div_operand_prep #(.W(DATA_W)) u_prep (
        .mode     (mode),
        .dividend (dividend),
        .divisor  (divisor),
        .num_mag  (prep_num),
        .den_mag  (prep_den),
        .flags    (prep_flags)
    );

    div_iter_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (bit_step),
        .num_in   (prep_num),
        .den_in   (prep_den),
        .part_rem (core_rem),
        .part_quo (core_quo)
    );

    div_sign_fix #(.W(DATA_W)) u_fix (
        .quo_mag  (core_quo),
        .rem_mag  (core_rem),
        .flags    (flags_q),
        .quo_out  (fix_quo),
        .rem_out  (fix_rem),
        .ovf_out  (fix_ovf)
    );

    // Sequence control: accept, count steps, raise done on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            step_cnt <= '0;
            flags_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                step_cnt <= '0;
                flags_q  <= prep_flags;
            end else if (advance) begin
                step_cnt <= step_cnt + 1'b1;
                if (step_cnt == LAST_STEP) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Correction stage: register the signed results after the bit steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_quo <= '0;
            stage_rem <= '0;
            stage_ovf <= 1'b0;
        end else if (advance && step_cnt == FIX_STEP) begin
            stage_quo <= fix_quo;
            stage_rem <= fix_rem;
            stage_ovf <= fix_ovf;
        end
    end

    // Result registers: written only on the completing step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            overflow  <= 1'b0;
        end else if (advance && step_cnt == LAST_STEP) begin
            quotient  <= stage_quo;
            remainder <= stage_rem;
            overflow  <= stage_ovf;
        end
    end

endmodule

// File: rtl/div_checker.sv
// Module: div_checker
// Handshake and timing properties of iter_divider, observed at its
// ports only. Bound to every instance of the top module below.
// Assumes: synchronous active-low reset on rst_n.
module div_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   mode,
    input logic [W-1:0] divisor,
    input logic         hold,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         overflow
);

    localparam int ITER  = W + 2;
    localparam int CW    = $clog2(ITER + 2) + 1;

    logic [CW-1:0] run_cnt;
    logic          zero_div;

    // Count non-held busy cycles of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (busy && !hold)
            run_cnt <= run_cnt + 1'b1;
        else if (!busy)
            run_cnt <= '0;
    end

    // Remember whether the accepted operation had a zero divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_div <= 1'b0;
        else if (start && !busy && mode <= 3'd4)
            zero_div <= (divisor == '0);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_cnt == CW'(ITER)); // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hold |=> busy && !done); // R8
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && run_cnt < CW'(ITER - 1) |=> busy); // R9
    AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && mode > 3'd4 |=> !busy); // R1
    AST_ZERO_DIV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done && zero_div |-> overflow); // R6
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient) && $stable(remainder) && $stable(overflow)); // R10

endmodule

bind iter_divider div_checker #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .divisor   (divisor),
    .hold      (hold),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .overflow  (overflow)
);

// File: tb/iter_divider_tb.sv
module iter_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        hold = 1'b0;
    logic        busy, done, overflow;
    logic [15:0] quotient, remainder;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string cur_tag = "R3";

    // reference model state
    bit          m_busy = 0, m_done = 0;
    int          m_steps = 0;
    bit          e_ov = 0;
    logic [15:0] e_q = '0, e_r = '0;
    string       e_tag = "R3";
    logic [15:0] m_q = '0, m_r = '0;
    logic        m_o = 1'b0;

    iter_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dividend(dividend), .divisor(divisor), .hold(hold),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .overflow(overflow)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural result per R1..R6, wide integer arithmetic.
    task automatic calc(input [2:0] md, input [31:0] a, input [15:0] b,
                        output bit ov, output logic [15:0] q, output logic [15:0] r);
        longint n, d, qq, rr;
        bit sgn;
        sgn = (md != 3'd0) && (md != 3'd2);
        case (md)
            3'd0:    begin n = longint'(a[15:0]); d = longint'(b); end
            3'd1:    begin n = longint'($signed(a[15:0])); d = longint'($signed(b)); end
            3'd2:    begin n = longint'(a); d = longint'(b); end
            3'd3:    begin n = longint'($signed(a)); d = longint'($signed(b)); end
            default: begin n = longint'($signed(a[15:0])) * 32768; d = longint'($signed(b)); end
        endcase
        if (d == 0) begin
            ov = 1; q = '0; r = '0;
        end else begin
            qq = n / d;
            rr = n % d;
            ov = sgn ? (qq > 32767 || qq < -32768) : (qq > 65535);
            q = qq[15:0];
            r = rr[15:0];
        end
    endtask

    // Cycle model of the handshake (R1, R7, R8, R9).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_steps = 0;
            m_q = '0; m_r = '0; m_o = 1'b0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (!hold) begin
                    m_steps++;
                    if (m_steps == 18) begin
                        m_busy = 0;
                        m_done = 1;
                    end
                end
            end else if (start && mode <= 3'd4) begin
                calc(mode, dividend, divisor, e_ov, e_q, e_r);
                e_tag = cur_tag;
                m_busy = 1;
                m_steps = 0;
            end
        end
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R7", "busy", busy, m_busy);
            chk(done === m_done, "R7", "done", done, m_done);
            if (m_done) begin
                chk(overflow === e_ov, e_ov ? "R6" : e_tag, "overflow", overflow, e_ov);
                if (!e_ov) begin
                    chk(quotient === e_q, e_tag, "quotient", quotient, e_q);
                    chk(remainder === e_r, e_tag, "remainder", remainder, e_r);
                end
                m_q = quotient; m_r = remainder; m_o = overflow;
            end else begin
                chk(quotient === m_q, "R10", "quotient held", quotient, m_q);
                chk(remainder === m_r, "R10", "remainder held", remainder, m_r);
                chk(overflow === m_o, "R10", "overflow held", overflow, m_o);
            end
        end
    end

    // One operation; start is driven at the current negedge.
    task automatic do_op(input [2:0] md, input [31:0] a, input [15:0] b,
                         input string tag, input bit hmode, input bit poke);
        cur_tag = tag;
        mode = md; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = $urandom;
        divisor = 16'($urandom);
        for (int i = 0; i < 200; i++) begin
            start = poke && (i == 4);
            if (poke && i == 4) begin
                mode = 3'd0; dividend = 32'd9; divisor = 16'd3;
            end
            hold = hmode && ($urandom % 3 == 0);
            @(negedge clk);
            if (done) break;
        end
        start = 1'b0;
        hold = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk(busy === 1'b0 && done === 1'b0, "R10", "reset busy/done", {busy, done}, 0);
        chk(quotient === 16'd0 && remainder === 16'd0 && overflow === 1'b0,
            "R10", "reset results", quotient, 0);

        do_op(3'd0, 32'd1000, 16'd7, "R3", 0, 0);
        do_op(3'd0, 32'hDEAD_0064, 16'd10, "R2", 0, 0);
        do_op(3'd0, 32'd65535, 16'd1, "R3", 0, 0);
        do_op(3'd1, 32'(-100), 16'd7, "R4", 0, 0);
        do_op(3'd1, 32'd100, 16'hFFF9, "R4", 0, 0);
        do_op(3'd1, 32'h0000_8000, 16'd1, "R4", 0, 0);
        do_op(3'd1, 32'h0000_8000, 16'hFFFF, "R6", 0, 0);
        do_op(3'd2, 32'h0001_0000, 16'd3, "R2", 0, 0);
        do_op(3'd2, 32'hFFFE_0001, 16'hFFFF, "R3", 0, 0);
        do_op(3'd2, 32'h0005_0000, 16'd5, "R6", 0, 0);
        do_op(3'd3, 32'(-100000), 16'd300, "R4", 0, 0);
        do_op(3'd3, 32'd100000, 16'hFED4, "R4", 0, 0);
        do_op(3'd4, 32'h0000_2000, 16'h4000, "R5", 0, 0);
        do_op(3'd4, 32'h0000_C000, 16'h4000, "R5", 0, 0);
        do_op(3'd4, 32'h0000_1234, 16'hB000, "R5", 0, 0);
        do_op(3'd4, 32'h0000_4000, 16'h2000, "R6", 0, 0);
        do_op(3'd1, 32'd77, 16'd0, "R6", 0, 0);

        // R1: unused mode codes are ignored
        for (int k = 5; k < 8; k++) begin
            mode = 3'(k); dividend = 32'd50; divisor = 16'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b0, "R1", "busy after unused mode", busy, 0);
        end

        // R9: start while busy; R8: random holds
        do_op(3'd1, 32'(-1234), 16'd10, "R9", 0, 1);
        do_op(3'd3, 32'h7FFF_0000, 16'h7FFF, "R8", 1, 0);
        do_op(3'd4, 32'h0000_F000, 16'h6000, "R8", 1, 1);

        for (int n = 0; n < 150; n++) begin
            logic [2:0]  md;
            logic [31:0] a;
            logic [15:0] b;
            md = 3'($urandom % 5);
            a = $urandom >> ($urandom % 17);
            if ($urandom % 2 == 1) a = -a;
            b = 16'($urandom >> ($urandom % 16));
            do_op(md, a, b, (md == 3'd4) ? "R5" : ((md == 3'd1 || md == 3'd3) ? "R4" : "R3"),
                  n % 3 == 0, n % 7 == 0);
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule